// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Memory

This block is a synchronous 8192-word by 8-bit read memory whose bits start at 0 and can be set to 1 once, one word at a time. It is made for a processor whose address and data share one bus. On the first clock edge where chip enable is seen active after being inactive, the block stores the 13-bit address in an internal latch. From then on the bus may carry data without disturbing the access.

The latched address is split into a row index and a column index over a 256-by-256 bit array. The row index selects one 256-bit row. The column index selects one 8-bit slice of that row. The read word is registered one clock after capture. It is presented on a data output with a separate output-enable signal, which stands in for a three-state pin.

A program strobe, held inactive high in normal use, merges a data byte into the word at the latched address with a bitwise OR. A stored 1 therefore never returns to 0.

Top module: `otp_latched_rom`

## Requirements
- R1: The address on `addr_i` is captured on the clock edge where `ce_n` is sampled low after having been sampled high on the previous edge (or since reset).
- R2: Once captured, the address stays fixed while `ce_n` remains low. Later changes on `addr_i` do not alter the word read until `ce_n` goes high and then low again.
- R3: With `ce_n` low, `oe_n` low and read data valid, `dout_en_o` is 1 and `dout_o` carries the stored word at the latched address.
- R4: With `ce_n` low and `oe_n` high, `dout_en_o` is 0 and `dout_o` is 0. The block stays enabled, so lowering `oe_n` shows the word again with no new capture.
- R5: With `ce_n` high, `dout_en_o` is 0 and `dout_o` is 0, whatever the level of `oe_n`.
- R6: After reset, every word reads as 8'h00.
- R7: A clock edge with `prog_n` low, `ce_n` low and an address already latched on an earlier edge sets the stored word to (old word | `pdata_i`). No bit ever goes from 1 to 0.
- R8: Read data becomes valid on the second edge of an access. After the capture edge, `dout_en_o` stays 0 until the next edge. After a program edge, the new word appears at the output one edge later.
- R9: The row index is address bits 9..2. The column index is {bit 12, bit 11, bit 10, bit 1, bit 0}. The word at column c occupies row bits c*8+7..c*8. Any two different addresses hold independent words.
- R10: While `prog_n` is high, `pdata_i` has no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array to all zeros |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_n | input | 1 | Program strobe, active low, held high in normal use |
| addr_i | input | 13 | Address half of the shared bus |
| pdata_i | input | 8 | Byte to merge into the latched word when programming |
| dout_o | output | 8 | Read data, 0 when not driven |
| dout_en_o | output | 1 | High when the data pins would be driven |

## Verification
The bench builds the block with its default parameters: 13 address bits, 8-bit words and the row field at bits 9..2. These defaults give the full 256-by-256 array. Every one of the 13 address bits can then be flipped against a base address to show that the row and column fields never alias. The same build reaches the extreme addresses 0 and 8191, and a second program on one word can be checked to only add bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int OTP_ADDR_W  = 13;
  localparam int OTP_DATA_W  = 8;
  localparam int OTP_ROW_LSB = 2;
  localparam int OTP_ROW_W   = 8;
endpackage

// File: rtl/otp_addr_latch.sv
module otp_addr_latch #(
  parameter int ADDR_W = otp_pkg::OTP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_act,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cap_o,
  output logic              ce_seen_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic ce_q;

  assign cap_o     = ce_act & ~ce_q;
  assign ce_seen_o = ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_o <= '0;
    end else begin
      ce_q <= ce_act;
      if (cap_o) addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int ADDR_W  = otp_pkg::OTP_ADDR_W,
  parameter int DATA_W  = otp_pkg::OTP_DATA_W,
  parameter int ROW_LSB = otp_pkg::OTP_ROW_LSB,
  parameter int ROW_W   = otp_pkg::OTP_ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rword_o
);
  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int ROW_BITS = DATA_W << COL_W;
  localparam int HI_LSB   = ROW_LSB + ROW_W;

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[HI_LSB-1:ROW_LSB];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:HI_LSB], a[ROW_LSB-1:0]};
  endfunction

  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_W-1:0]    row;
  logic [COL_W-1:0]    col;

  assign row     = row_of(addr_i);
  assign col     = col_of(addr_i);
  assign rword_o = mem[row][col*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[row][col*DATA_W +: DATA_W] <= rword_o | wdata_i;
    end
  end
endmodule

// File: rtl/otp_out_ctrl.sv
module otp_out_ctrl #(
  parameter int DATA_W = otp_pkg::OTP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_act,
  input  logic              ce_seen,
  input  logic              oe_act,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic [DATA_W-1:0] rd_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      rd_q  <= word_i;
      vld_q <= ce_act & ce_seen;
    end
  end

  assign dout_en_o = ce_act & oe_act & vld_q;
  assign dout_o    = dout_en_o ? rd_q : '0;
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom #(
  parameter int ADDR_W  = otp_pkg::OTP_ADDR_W,
  parameter int DATA_W  = otp_pkg::OTP_DATA_W,
  parameter int ROW_LSB = otp_pkg::OTP_ROW_LSB,
  parameter int ROW_W   = otp_pkg::OTP_ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] pdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic              ce_act;
  logic              cap_w;
  logic              ce_seen_w;
  logic              prog_w;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] cur_word;

  assign ce_act = ~ce_n;
  // programming uses an address latched on an earlier edge
  assign prog_w = ce_act & ce_seen_w & ~prog_n;

  otp_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ce_act(ce_act), .addr_i(addr_i),
    .cap_o(cap_w), .ce_seen_o(ce_seen_w), .addr_o(lat_addr)
  );

  otp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_LSB(ROW_LSB), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst_n(rst_n), .addr_i(lat_addr), .wr_en(prog_w),
    .wdata_i(pdata_i), .rword_o(cur_word)
  );

  otp_out_ctrl #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ce_act(ce_act), .ce_seen(ce_seen_w),
    .oe_act(~oe_n), .word_i(cur_word), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );
endmodule

// File: rtl/otp_latched_rom_chk.sv
module otp_latched_rom_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              cap_w,
  input logic              prog_w,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [DATA_W-1:0] cur_word,
  input logic [DATA_W-1:0] pdata_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_en_o
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_w |=> $stable(lat_addr));

  p_cap_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_w |=> !cap_w);

  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> (!dout_en_o && dout_o == '0));

  p_disabled_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_en_o && dout_o == '0));

  p_or_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_w |=> ((cur_word & $past(pdata_i)) == $past(pdata_i)
                && (cur_word & $past(cur_word)) == $past(cur_word)));

  p_no_early_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_w |=> !dout_en_o);
endmodule

bind otp_latched_rom otp_latched_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .cap_w(cap_w),
  .prog_w(prog_w), .lat_addr(lat_addr), .cur_word(cur_word),
  .pdata_i(pdata_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
);

// File: tb/otp_latched_rom_tb.sv
module otp_latched_rom_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1;
  logic [12:0] addr_i = '0;
  logic [7:0]  pdata_i = '0;
  logic [7:0]  dout_o;
  logic        dout_en_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  otp_latched_rom u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_n(prog_n),
    .addr_i(addr_i), .pdata_i(pdata_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual={en,data}=%h expected=%h", req, act, exp);
    end
  endtask

  // start an access: leave a disabled edge, then capture on the next edge
  task automatic open_access(input logic [12:0] a, input string req);
    @(negedge clk); ce_n = 1'b1; prog_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; addr_i = a;
    @(negedge clk); chk({req, " capture edge: no data yet"}, {dout_en_o, dout_o}, 9'h000);
    addr_i = ~a;               // bus now carries something else
    @(negedge clk);
  endtask

  task automatic program_byte(input logic [7:0] d);
    prog_n = 1'b0; pdata_i = d;
    @(negedge clk); prog_n = 1'b1; pdata_i = 8'h00;
    @(negedge clk);
  endtask

  task automatic read_expect(input logic [12:0] a, input logic [7:0] e, input string req);
    oe_n = 1'b0;
    open_access(a, req);
    chk(req, {dout_en_o, dout_o}, {1'b1, e});
  endtask

  task automatic t_reset;
    chk("R5 reset idle", {dout_en_o, dout_o}, 9'h000);
    read_expect(13'h0000, 8'h00, "R6 fresh addr 0");
    read_expect(13'h1FFF, 8'h00, "R6 fresh addr 1FFF");
  endtask

  task automatic t_program_or;
    oe_n = 1'b0;
    open_access(13'h1234, "R1");
    program_byte(8'h05);
    chk("R7 first program", {dout_en_o, dout_o}, 9'h105);
    program_byte(8'h30);
    chk("R7 OR merge", {dout_en_o, dout_o}, 9'h135);
    program_byte(8'h00);
    chk("R7 no clear", {dout_en_o, dout_o}, 9'h135);
    read_expect(13'h1234, 8'h35, "R3 reread after new capture");
  endtask

  task automatic t_latch_hold;
    oe_n = 1'b0;
    open_access(13'h1234, "R2");
    repeat (3) begin
      addr_i = addr_i + 13'd7;
      @(negedge clk);
      chk("R2 bus change ignored", {dout_en_o, dout_o}, 9'h135);
    end
  endtask

  task automatic t_output_gating;
    oe_n = 1'b1;
    open_access(13'h1234, "R4");
    chk("R4 oe off while enabled", {dout_en_o, dout_o}, 9'h000);
    oe_n = 1'b0; #1;
    chk("R4 oe back on, no new capture", {dout_en_o, dout_o}, 9'h135);
    @(negedge clk); ce_n = 1'b1; #1;
    chk("R5 ce off oe on", {dout_en_o, dout_o}, 9'h000);
    oe_n = 1'b1; #1;
    chk("R5 ce off oe off", {dout_en_o, dout_o}, 9'h000);
  endtask

  task automatic t_decode;
    logic [12:0] base = 13'h0AAA;
    oe_n = 1'b0;
    open_access(base, "R9");
    program_byte(8'h5A);
    for (int i = 0; i < 13; i++)
      read_expect(base ^ (13'd1 << i), 8'h00, $sformatf("R9 neighbour bit %0d", i));
    read_expect(base, 8'h5A, "R9 base word");
  endtask

  task automatic t_prog_idle;
    oe_n = 1'b0;
    open_access(13'h0F0F, "R10");
    pdata_i = 8'hFF;
    repeat (3) @(negedge clk);
    pdata_i = 8'h00;
    chk("R10 data without strobe", {dout_en_o, dout_o}, 9'h100);
    read_expect(13'h0F0F, 8'h00, "R10 reread");
  endtask

  task automatic t_timing;
    oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; addr_i = 13'h1234;
    @(negedge clk); chk("R8 after capture edge", {dout_en_o, dout_o}, 9'h000);
    @(negedge clk); chk("R8 second edge valid", {dout_en_o, dout_o}, 9'h135);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program_or();
    t_latch_hold();
    t_output_gating();
    t_decode();
    t_prog_idle();
    t_timing();
    @(negedge clk); ce_n = 1'b1;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule